// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write side of a shared buffer that holds four logical queues. Several such buffers can share one address bus, and each is told apart by a static 3-bit identity. A 5-bit address is taken on any clock edge where the address-enable input is high. The upper three bits name a device and the lower two bits name a queue. Data is offered on every clock, and an active-low write enable qualifies it. The block passes a write strobe, the target queue and the data on to the storage array. It also drives a full flag for the queue that is currently active.

A queue switch moves through a two-stage pipeline, so the data bus never idles. On the edge that selects a queue, and on the edge after it, writes still land in the old queue. The full flag moves to the new queue at that second edge. The first write into the new queue happens at the third edge. Each queue keeps an occupancy count, and a per-queue decrement strobe stands in for the read side. A selection that arrives too soon after the last one is dropped and raises a sticky error flag.

Top module: `mq_write_selector`

## Requirements
- R1: The address is taken only on an edge where addr_en is 1. The level of wr_en_n has no bearing on whether a selection is made.
- R2: Address bits [4:2] are compared with dev_id and bits [1:0] give the queue. A selection whose device bits differ from dev_id deselects the block after the same pipeline. While the block is deselected, mem_we and full stay 0.
- R3: The active queue stays the same until a later selection is accepted.
- R4: On the selection edge and the edge after it, a write with wr_en_n at 0 goes to the previously active queue.
- R5: full shows the status of the new queue from the first edge after the selection edge onward.
- R6: From the second edge after selection, mem_we is 1 with mem_wq equal to the new queue whenever wr_en_n is 0 and that queue is not full. mem_wdata equals wr_data.
- R7: A full queue takes no write, including a queue that is already full when it is selected.
- R8: A selection fewer than MIN_GAP (3) edges after the last accepted selection is ignored. It sets proto_err, which stays at 1 until reset.
- R9: Each queue count saturates at DEPTH/4, and full is 1 exactly at that value. A decrement of an empty queue leaves the count at 0.
- R10: A write and a decrement to the same queue on the same edge leave that queue's count unchanged.
- R11: After reset no queue is active, all counts are 0, and full, mem_we and proto_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | DATA_W | Write data |
| wr_en_n | input | 1 | Write enable, active low |
| addr_en | input | 1 | Address enable; the address is taken when this is 1 |
| wr_addr | input | 5 | Device select in [4:2], queue number in [1:0] |
| dev_id | input | 3 | Static identity of this device |
| rd_dec | input | 4 | Per-queue occupancy decrement strobes |
| mem_we | output | 1 | A write is accepted on the coming edge |
| mem_wq | output | 2 | Queue that receives the write |
| mem_wdata | output | DATA_W | Data for the write |
| full | output | 1 | The active queue is full |
| proto_err | output | 1 | Sticky flag for a selection that came too early |

## Verification
mem_we, mem_wq and mem_wdata are combinational from the inputs and the state left by the last edge, so they describe the write that the coming edge performs. full changes one edge after the edge that selects a queue. The new queue's number first shows on mem_wq in the cycle that follows, ahead of the second edge. proto_err rises one edge after the early address. The bench drives each cycle's inputs just after the falling edge and samples one time unit later, before the rising edge. Each vector row therefore gives the values the design must show in the cycle that row is driven.

// File: rtl/mq_wr_pkg.sv
// Shared definitions for the multi-queue write port.
// Assumes four queues per device and up to eight devices on one address bus.
package mq_wr_pkg;
    localparam int DEV_W   = 3;
    localparam int QADDR_W = 2;
    localparam int ADDR_W  = DEV_W + QADDR_W;
    localparam int NUM_Q   = 1 << QADDR_W;

    // Write address split: device select in the upper bits, queue in the lower bits.
    typedef struct packed {
        logic [DEV_W-1:0]   dev;
        logic [QADDR_W-1:0] q;
    } wr_addr_t;
endpackage

// File: rtl/mq_sel_pipe.sv
// Queue selection pipeline. It takes an address on addr_en, checks the device
// bits against dev_id and makes the choice active one edge later.
// Selections closer together than MIN_GAP edges are dropped and flagged.
// Assumes MIN_GAP >= 2, so that no selection can enter while one is in flight.
module mq_sel_pipe
    import mq_wr_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DEV_W-1:0]   dev_id,
    output logic               act_on,
    output logic [QADDR_W-1:0] act_q,
    output logic               pend_valid,
    output logic               proto_err
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_C = GW'(MIN_GAP);

    wr_addr_t           addr_s;
    logic [GW-1:0]      age;
    logic               accept;
    logic [QADDR_W-1:0] pend_q;
    logic               pend_match;

    // Decode the address and decide whether this selection may enter.
    always_comb begin
        addr_s = wr_addr_t'(wr_addr);
        accept = addr_en && (age >= GAP_C);
    end

    // Count edges since the last accepted selection, saturating at MIN_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= GAP_C;
        else if (accept)     age <= GW'(1);
        else if (age < GAP_C) age <= age + GW'(1);
    end

    // Stage one: hold the captured selection for one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_q     <= '0;
            pend_match <= 1'b0;
        end else begin
            pend_valid <= accept;
            if (accept) begin
                pend_q     <= addr_s.q;
                pend_match <= (addr_s.dev == dev_id);
            end
        end
    end

    // Stage two: make the pending selection the active one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on <= 1'b0;
            act_q  <= '0;
        end else if (pend_valid) begin
            act_on <= pend_match;
            act_q  <= pend_q;
        end
    end

    // Sticky flag for an address that came too soon.
    always_ff @(posedge clk) begin
        if (!rst_n)                   proto_err <= 1'b0;
        else if (addr_en && !accept)  proto_err <= 1'b1;
    end
endmodule

// File: rtl/mq_occ_counter.sv
// Occupancy count for one queue. It rises on a write and falls on a decrement,
// saturates at CAP and at zero, and holds when both arrive on the same edge.
// Assumes the writer never raises inc while is_full is 1.
module mq_occ_counter #(
    parameter int CAP = 16,
    parameter int CW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          is_full
);
    localparam logic [CW-1:0] CAP_C = CW'(CAP);

    // Full when the count reaches capacity.
    always_comb is_full = (cnt == CAP_C);

    // Bounded up/down count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && !dec && cnt < CAP_C)
            cnt <= cnt + CW'(1);
        else if (dec && !inc && cnt != '0)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/mq_write_selector.sv
// Write-side selector for a four-queue shared buffer. It routes each write to
// the active queue, blocks writes into a full queue and drives that queue's
// full flag. Queue switches take effect through a two-edge pipeline.
// Assumes the storage array takes mem_we/mem_wq/mem_wdata on the next edge.
module mq_write_selector
    import mq_wr_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int DEPTH   = 64,
    parameter int MIN_GAP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_en_n,
    input  logic               addr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DEV_W-1:0]   dev_id,
    input  logic [NUM_Q-1:0]   rd_dec,
    output logic               mem_we,
    output logic [QADDR_W-1:0] mem_wq,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               full,
    output logic               proto_err
);
    localparam int CAP = DEPTH / NUM_Q;
    localparam int CW  = $clog2(CAP + 1);

    logic                        act_on;
    logic [QADDR_W-1:0]          act_q;
    logic                        pend_valid;
    logic [NUM_Q-1:0][CW-1:0]    occ;
    logic [NUM_Q-1:0]            q_full;

    mq_sel_pipe #(.MIN_GAP(MIN_GAP)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_en    (addr_en),
        .wr_addr    (wr_addr),
        .dev_id     (dev_id),
        .act_on     (act_on),
        .act_q      (act_q),
        .pend_valid (pend_valid),
        .proto_err  (proto_err)
    );

    // Gate the write by the active queue and its fullness.
    always_comb begin
        full      = act_on && q_full[act_q];
        mem_we    = act_on && !wr_en_n && !q_full[act_q];
        mem_wq    = act_q;
        mem_wdata = wr_data;
    end

    // One occupancy counter per queue.
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        logic inc_i;
        always_comb inc_i = mem_we && (act_q == QADDR_W'(i));
        mq_occ_counter #(.CAP(CAP), .CW(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_i),
            .dec     (rd_dec[i]),
            .cnt     (occ[i]),
            .is_full (q_full[i])
        );
    end
endmodule

// File: rtl/mq_wr_checker.sv
// Properties of the write selector, attached to every instance by bind.
module mq_wr_checker #(
    parameter int NUM_Q = 4,
    parameter int CAP   = 16,
    parameter int CW    = 5,
    parameter int QW    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mem_we,
    input logic [QW-1:0]            mem_wq,
    input logic [NUM_Q-1:0]         rd_dec,
    input logic                     proto_err,
    input logic                     act_on,
    input logic [QW-1:0]            act_q,
    input logic                     pend_valid,
    input logic [NUM_Q-1:0][CW-1:0] occ
);
    localparam logic [CW-1:0] CAP_C = CW'(CAP);

    a_r8_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r3_hold_queue: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |=> ($stable(act_q) && $stable(act_on)));

    a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (occ[mem_wq] < CAP_C));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
        a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
            occ[i] <= CAP_C);
        a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[i] == '0 && rd_dec[i] && !(mem_we && mem_wq == QW'(i)))
            |=> (occ[i] == '0));
        a_r10_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_we && mem_wq == QW'(i) && rd_dec[i]) |=> $stable(occ[i]));
    end
endmodule

bind mq_write_selector mq_wr_checker #(
    .NUM_Q(NUM_Q), .CAP(CAP), .CW(CW), .QW(QADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_wq(mem_wq),
    .rd_dec(rd_dec), .proto_err(proto_err), .act_on(act_on),
    .act_q(act_q), .pend_valid(pend_valid), .occ(occ)
);

// File: tb/test_mq_write_selector.sv
module test_mq_write_selector;
    localparam int PERIOD = 10;
    localparam int DATA_W = 18;
    localparam int NROWS  = 19;
    localparam logic [2:0] ID = 3'b101;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_en_n = 1'b1;
    logic              addr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [3:0]        rd_dec = '0;
    logic              mem_we, full, proto_err;
    logic [1:0]        mem_wq;
    logic [DATA_W-1:0] mem_wdata;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mq_write_selector #(.DATA_W(DATA_W), .DEPTH(16), .MIN_GAP(3)) i_mq_write_selector (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en_n(wr_en_n),
        .addr_en(addr_en), .wr_addr(wr_addr), .dev_id(ID), .rd_dec(rd_dec),
        .mem_we(mem_we), .mem_wq(mem_wq), .mem_wdata(mem_wdata),
        .full(full), .proto_err(proto_err)
    );

    // Row: addr_en, addr[4:0], wr_en_n, rd_dec[3:0], exp_we, exp_wq[1:0], exp_full, exp_err
    // Capacity per queue is 4. Each row gives the values expected in the cycle it is driven.
    localparam logic [15:0] VEC [NROWS] = '{
        {1'b1, 5'b10100, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 0  R11 none active; select q0
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 1  R4 old (none) still active
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd0, 1'b0, 1'b0}, // 2  R6 first write to q0
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd0, 1'b0, 1'b0}, // 3
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd0, 1'b0, 1'b0}, // 4
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd0, 1'b0, 1'b0}, // 5  q0 reaches 4
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 1'b0}, // 6  R7 blocked
        {1'b0, 5'b00000, 1'b0, 4'b0001, 1'b0, 2'd0, 1'b1, 1'b0}, // 7  R9 decrement q0
        {1'b0, 5'b00000, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 8  q0 at 3
        {1'b1, 5'b10110, 1'b0, 4'b0000, 1'b1, 2'd0, 1'b0, 1'b0}, // 9  R1 select q2 while writing q0
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 1'b0}, // 10 R4 old q0 now full
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd2, 1'b0, 1'b0}, // 11 R5/R6 q2 active
        {1'b1, 5'b01101, 1'b0, 4'b0000, 1'b1, 2'd2, 1'b0, 1'b0}, // 12 R2 foreign device select
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b1, 2'd2, 1'b0, 1'b0}, // 13 R3 still q2
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 14 R2 deselected
        {1'b1, 5'b10100, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 15 select full q0
        {1'b1, 5'b10101, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0}, // 16 R8 too early
        {1'b0, 5'b00000, 1'b0, 4'b0000, 1'b0, 2'd0, 1'b1, 1'b1}, // 17 R7 full at selection; R8 err
        {1'b0, 5'b00000, 1'b0, 4'b0100, 1'b0, 2'd0, 1'b1, 1'b1}  // 18 R8 q1 ignored, still q0
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic ae, input logic [4:0] a, input logic wn, input logic [3:0] rd);
        @(negedge clk);
        addr_en = ae; wr_addr = a; wr_en_n = wn; rd_dec = rd;
        wr_data = wr_data + 18'h123;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; addr_en = 1'b0; wr_en_n = 1'b0; rd_dec = '0;
        repeat (2) @(negedge clk);
        #1;
        chk(full, 0, "R11 full in reset");
        chk(mem_we, 0, "R11 mem_we in reset");
        chk(proto_err, 0, "R11 proto_err in reset");
        @(negedge clk);
        rst_n = 1'b1; wr_en_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int r = 0; r < NROWS; r++) begin
            logic [15:0] v;
            v = VEC[r];
            drive(v[15], v[14:10], v[9], v[8:5]);
            chk(mem_we, v[4], $sformatf("R4/R6/R7 row %0d mem_we", r));
            if (v[4]) begin
                chk(mem_wq, v[3:2], $sformatf("R4/R6 row %0d mem_wq", r));
                chk(mem_wdata, wr_data, $sformatf("R6 row %0d mem_wdata", r));
            end
            chk(full, v[1], $sformatf("R5/R2 row %0d full", r));
            chk(proto_err, v[0], $sformatf("R8 row %0d proto_err", r));
        end

        // R11: reset mid-run clears the error and the selection.
        do_reset();
        drive(1'b0, 5'b0, 1'b0, 4'b0);
        chk(mem_we, 0, "R11 no queue after reset");
        chk(proto_err, 0, "R11 err cleared");

        // R10: write and decrement on the same edge keep the count.
        drive(1'b1, {ID, 2'd1}, 1'b1, 4'b0);
        drive(1'b0, 5'b0, 1'b1, 4'b0);
        for (int k = 0; k < 3; k++) drive(1'b0, 5'b0, 1'b0, 4'b0);
        drive(1'b0, 5'b0, 1'b0, 4'b0010);
        chk(mem_we, 1, "R10 write with decrement");
        drive(1'b0, 5'b0, 1'b1, 4'b0);
        chk(full, 0, "R10 count held at 3");
        drive(1'b0, 5'b0, 1'b0, 4'b0);
        chk(mem_we, 1, "R10 fourth write");
        drive(1'b0, 5'b0, 1'b1, 4'b0);
        chk(full, 1, "R10 full after fourth");

        // R9: decrements of an empty queue do not wrap.
        drive(1'b1, {ID, 2'd3}, 1'b1, 4'b0);
        drive(1'b0, 5'b0, 1'b1, 4'b1000);
        drive(1'b0, 5'b0, 1'b1, 4'b1000);
        chk(full, 0, "R9 empty q3 not full");
        for (int k = 0; k < 3; k++) drive(1'b0, 5'b0, 1'b0, 4'b0);
        drive(1'b0, 5'b0, 1'b1, 4'b0);
        chk(full, 0, "R9 q3 at 3");
        drive(1'b0, 5'b0, 1'b0, 4'b0);
        drive(1'b0, 5'b0, 1'b1, 4'b0);
        chk(full, 1, "R9 q3 full at capacity");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule